// File: doc/BRIEF.md
# Framebuffer Acquisition Sequencer

This block is a bus master that obtains a framebuffer from a display coprocessor. The coprocessor is reached through a memory-mapped mailbox. When `start` is pulsed, the sequencer writes a ten-word request record into shared memory, one word per access. It then waits until the outgoing mailbox has room and posts the record's address tagged with the framebuffer channel. After that it polls the incoming side for the coprocessor's answer.

Answers that arrive on any other channel are dropped. Once its own answer is in, the sequencer reads back the pitch, pointer and size words that the coprocessor filled into the record. Success requires two things: the answer's data field is zero and the returned pointer is non-zero. If either test fails, the whole build, post and wait cycle is repeated. A bounded attempt count ends the loop with an error flag, so the sequencer cannot spin forever.

Both the mailbox side and the memory side are simple request/acknowledge ports with one access in flight. A request and its address, write flag and write data stay steady until a one-cycle acknowledge. Read data is valid in the acknowledge cycle.

Top module: `fbq_acquire`

## Requirements
- R1: While reset is held and right after it is released, `done`, `ok`, `err`, `mb_req` and `mem_req` are low.
- R2: After `start`, ten memory writes are made to `REC_BASE + 4*i` for i = 0..9. Their values in index order are 640, 480, 640, 480, 0, 24, 0, 0, 0, 0: width, height, virtual width, virtual height, pitch, depth, x offset, y offset, pointer, size.
- R3: The mailbox status register (offset 0x18) is read before each post. No write to offset 0x20 is issued while the last status read had bit 31 (outbox full) set.
- R4: Every mailbox write goes to offset 0x20 and carries the record base in bits 31:4 and channel 1 in bits 3:0. With the default base this is 0x0040_0001.
- R5: The message register (offset 0x00) is read only after a status read showed bit 30 (inbox empty) clear.
- R6: A message whose bits 3:0 are not 1 is discarded, and the sequencer returns to polling status. Each such message costs exactly one extra read of offset 0x00.
- R7: An attempt succeeds only when bits 31:4 of the accepted message are zero and the pointer word (record offset 32) is non-zero. The words at record offsets 16, 32 and 36 are presented on `fb_pitch`, `fb_ptr` and `fb_size`.
- R8: A failed attempt causes all ten record words to be rewritten with the R2 values and a new post. The number of posts equals the number of attempts made.
- R9: After `RETRY_MAX` failed attempts (default 16), the run ends with `err` high and `ok` low, and no further post is made.
- R10: `done` is high for exactly one cycle per run. `ok`, `err` and the three result outputs hold until the next `start`, which clears `ok` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an acquisition run (sampled in idle) |
| mb_req | output | 1 | Mailbox access request |
| mb_we | output | 1 | Mailbox access is a write |
| mb_addr | output | 8 | Mailbox register offset |
| mb_wdata | output | 32 | Mailbox write data |
| mb_ack | input | 1 | Mailbox access complete |
| mb_rdata | input | 32 | Mailbox read data, valid with `mb_ack` |
| mem_req | output | 1 | Record memory access request |
| mem_we | output | 1 | Record memory access is a write |
| mem_addr | output | 32 | Record memory byte address |
| mem_wdata | output | 32 | Record memory write data |
| mem_ack | input | 1 | Record memory access complete |
| mem_rdata | input | 32 | Record memory read data, valid with `mem_ack` |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Framebuffer acquired |
| err | output | 1 | Attempt limit reached |
| fb_pitch | output | 32 | Returned bytes per row |
| fb_ptr | output | 32 | Returned framebuffer address |
| fb_size | output | 32 | Returned framebuffer size |

## Verification
A corrupted record index shows up at once, on the next memory request, as a write to the wrong address or with the wrong word value. The coprocessor model compares the whole record at every post, so a stale field is caught at the post of the attempt that carries it. A wrong attempt count appears at the end of the run as too few or too many posts, or as an `err` one attempt early or late. A channel-filter fault shows as an extra or missing read of the message register, and it usually also causes one spurious retry. A control state that fails to release a request leaves the port handshake stuck, so the run never reaches `done`.

// File: rtl/fbq_pkg.sv
package fbq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUILD,
        ST_TXPOLL,
        ST_POST,
        ST_RXPOLL,
        ST_FETCH,
        ST_READBACK,
        ST_JUDGE
    } fbq_state_e;

    localparam int unsigned IDX_W     = 4;
    localparam int unsigned REC_WORDS = 10;

    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(REC_WORDS - 1);
    localparam logic [IDX_W-1:0] IDX_PITCH = IDX_W'(4);
    localparam logic [IDX_W-1:0] IDX_PTR   = IDX_W'(8);
    localparam logic [IDX_W-1:0] IDX_SIZE  = IDX_W'(9);

    localparam logic [7:0] OFS_MSG   = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h18;
    localparam logic [7:0] OFS_WRITE = 8'h20;

endpackage

// File: rtl/fbq_rec_word.sv
module fbq_rec_word #(
    parameter int unsigned    DW     = 32,
    parameter int unsigned    IW     = 4,
    parameter logic [DW-1:0]  WIDTH  = 640,
    parameter logic [DW-1:0]  HEIGHT = 480,
    parameter logic [DW-1:0]  DEPTH  = 24
) (
    input  logic [IW-1:0] idx,
    output logic [DW-1:0] word
);

    // Requested geometry; every field the coprocessor fills in is sent as zero.
    always_comb begin
        case (idx)
            IW'(0):  word = WIDTH;
            IW'(1):  word = HEIGHT;
            IW'(2):  word = WIDTH;
            IW'(3):  word = HEIGHT;
            IW'(5):  word = DEPTH;
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/fbq_reply_check.sv
module fbq_reply_check #(
    parameter int unsigned DW   = 32,
    parameter int unsigned CH_W = 4,
    parameter int unsigned CHAN = 1
) (
    input  logic [DW-1:0] msg,
    output logic          chan_hit,
    output logic          data_zero
);

    always_comb begin
        chan_hit  = (msg[CH_W-1:0] == CH_W'(CHAN));
        data_zero = (msg[DW-1:CH_W] == '0);
    end

endmodule

// File: rtl/fbq_try_ctr.sv
module fbq_try_ctr #(
    parameter int unsigned MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int unsigned CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
        last = (cnt_q == CW'(MAX - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/fbq_acquire.sv
module fbq_acquire
    import fbq_pkg::*;
#(
    parameter int unsigned   DW         = 32,
    parameter int unsigned   AW         = 32,
    parameter int unsigned   OFS_W      = 8,
    parameter int unsigned   CH_W       = 4,
    parameter int unsigned   CHAN       = 1,
    parameter logic [AW-1:0] REC_BASE   = 32'h0040_0000,
    parameter logic [DW-1:0] REQ_WIDTH  = 640,
    parameter logic [DW-1:0] REQ_HEIGHT = 480,
    parameter logic [DW-1:0] REQ_DEPTH  = 24,
    parameter int unsigned   RETRY_MAX  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             mb_req,
    output logic             mb_we,
    output logic [OFS_W-1:0] mb_addr,
    output logic [DW-1:0]    mb_wdata,
    input  logic             mb_ack,
    input  logic [DW-1:0]    mb_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             done,
    output logic             ok,
    output logic             err,
    output logic [DW-1:0]    fb_pitch,
    output logic [DW-1:0]    fb_ptr,
    output logic [DW-1:0]    fb_size
);

    localparam int unsigned   FULL_BIT  = DW - 1;
    localparam int unsigned   EMPTY_BIT = DW - 2;
    localparam logic [DW-1:0] POST_MSG  = DW'({REC_BASE[AW-1:CH_W], CH_W'(CHAN)});

    typedef struct packed {
        fbq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             rep_zero;
        logic [DW-1:0]    pitch;
        logic [DW-1:0]    ptr;
        logic [DW-1:0]    size;
        logic             done;
        logic             ok;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;

    logic [DW-1:0] rec_word;
    logic          chan_hit, data_zero;
    logic          try_clr, try_inc, try_last;

    fbq_rec_word #(
        .DW(DW), .IW(IDX_W),
        .WIDTH(REQ_WIDTH), .HEIGHT(REQ_HEIGHT), .DEPTH(REQ_DEPTH)
    ) u_word (
        .idx  (r_q.idx),
        .word (rec_word)
    );

    fbq_reply_check #(
        .DW(DW), .CH_W(CH_W), .CHAN(CHAN)
    ) u_reply (
        .msg       (mb_rdata),
        .chan_hit  (chan_hit),
        .data_zero (data_zero)
    );

    fbq_try_ctr #(
        .MAX(RETRY_MAX)
    ) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (try_clr),
        .inc   (try_inc),
        .last  (try_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        try_clr   = 1'b0;
        try_inc   = 1'b0;

        mb_req    = 1'b0;
        mb_we     = 1'b0;
        mb_addr   = '0;
        mb_wdata  = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = REC_BASE + (AW'(r_q.idx) << 2);
        mem_wdata = rec_word;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_BUILD;
                    r_d.idx   = '0;
                    r_d.ok    = 1'b0;
                    r_d.err   = 1'b0;
                    r_d.pitch = '0;
                    r_d.ptr   = '0;
                    r_d.size  = '0;
                    try_clr   = 1'b1;
                end
            end
            ST_BUILD: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    if (r_q.idx == IDX_LAST) begin
                        r_d.st = ST_TXPOLL;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_TXPOLL: begin
                mb_req  = 1'b1;
                mb_addr = OFS_W'(OFS_STAT);
                if (mb_ack && !mb_rdata[FULL_BIT]) begin
                    r_d.st = ST_POST;
                end
            end
            ST_POST: begin
                mb_req   = 1'b1;
                mb_we    = 1'b1;
                mb_addr  = OFS_W'(OFS_WRITE);
                mb_wdata = POST_MSG;
                if (mb_ack) begin
                    r_d.st = ST_RXPOLL;
                end
            end
            ST_RXPOLL: begin
                mb_req  = 1'b1;
                mb_addr = OFS_W'(OFS_STAT);
                if (mb_ack && !mb_rdata[EMPTY_BIT]) begin
                    r_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mb_req  = 1'b1;
                mb_addr = OFS_W'(OFS_MSG);
                if (mb_ack) begin
                    if (chan_hit) begin
                        r_d.rep_zero = data_zero;
                        r_d.idx      = IDX_PITCH;
                        r_d.st       = ST_READBACK;
                    end else begin
                        r_d.st = ST_RXPOLL;
                    end
                end
            end
            ST_READBACK: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (r_q.idx == IDX_PITCH) begin
                        r_d.pitch = mem_rdata;
                        r_d.idx   = IDX_PTR;
                    end else if (r_q.idx == IDX_PTR) begin
                        r_d.ptr = mem_rdata;
                        r_d.idx = IDX_SIZE;
                    end else begin
                        r_d.size = mem_rdata;
                        r_d.st   = ST_JUDGE;
                    end
                end
            end
            ST_JUDGE: begin
                if (r_q.rep_zero && (r_q.ptr != '0)) begin
                    r_d.ok   = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (try_last) begin
                    r_d.err  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    try_inc = 1'b1;
                    r_d.idx = '0;
                    r_d.st  = ST_BUILD;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = r_q.done;
    assign ok       = r_q.ok;
    assign err      = r_q.err;
    assign fb_pitch = r_q.pitch;
    assign fb_ptr   = r_q.ptr;
    assign fb_size  = r_q.size;

endmodule

// File: rtl/fbq_acquire_chk.sv
module fbq_acquire_chk #(
    parameter int unsigned   DW       = 32,
    parameter int unsigned   AW       = 32,
    parameter int unsigned   OFS_W    = 8,
    parameter int unsigned   CH_W     = 4,
    parameter int unsigned   CHAN     = 1,
    parameter logic [AW-1:0] REC_BASE = 32'h0040_0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             ok,
    input logic             err,
    input logic             mb_req,
    input logic             mb_we,
    input logic [OFS_W-1:0] mb_addr,
    input logic [DW-1:0]    mb_wdata,
    input logic             mb_ack,
    input logic             mem_req,
    input logic [AW-1:0]    mem_addr
);

    localparam logic [AW-1:0] REC_END = REC_BASE + AW'(4 * fbq_pkg::REC_WORDS);
    localparam logic [DW-1:0] EXP_MSG = DW'({REC_BASE[AW-1:CH_W], CH_W'(CHAN)});

    AST_POST_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && mb_we) |-> (mb_addr == OFS_W'(8'h20) && mb_wdata == EXP_MSG)); // R4

    AST_MB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && !mb_ack) |=> (mb_req && $stable(mb_addr) && $stable(mb_we))); // R3

    AST_REC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00 && mem_addr >= REC_BASE && mem_addr < REC_END)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && err)); // R9

    AST_OK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(ok) || done)); // R10

endmodule

bind fbq_acquire fbq_acquire_chk #(
    .DW(DW), .AW(AW), .OFS_W(OFS_W), .CH_W(CH_W), .CHAN(CHAN), .REC_BASE(REC_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .ok       (ok),
    .err      (err),
    .mb_req   (mb_req),
    .mb_we    (mb_we),
    .mb_addr  (mb_addr),
    .mb_wdata (mb_wdata),
    .mb_ack   (mb_ack),
    .mem_req  (mem_req),
    .mem_addr (mem_addr)
);

// File: tb/sim_fbq_acquire.sv
module sim_fbq_acquire;

    localparam logic [31:0] BASE   = 32'h0040_0000;
    localparam int          RMAX   = 16;
    localparam logic [31:0] G_PITCH = 32'd1920;
    localparam logic [31:0] G_PTR   = 32'h0080_0000;
    localparam logic [31:0] G_SIZE  = 32'd921600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #5 clk = ~clk;

    logic        mb_req, mb_we, mb_ack = 1'b0;
    logic [7:0]  mb_addr;
    logic [31:0] mb_wdata, mb_rdata = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        done, ok, err;
    logic [31:0] fb_pitch, fb_ptr, fb_size;

    fbq_acquire u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mb_req(mb_req), .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
        .mb_ack(mb_ack), .mb_rdata(mb_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .ok(ok), .err(err),
        .fb_pitch(fb_pitch), .fb_ptr(fb_ptr), .fb_size(fb_size)
    );

    typedef struct {
        bit          ok;
        bit          err;
        int          tries;
        int          reads;
        logic [31:0] pitch;
        logic [31:0] ptr;
        logic [31:0] size;
        bit          vals;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] rxq[$];
    logic [31:0] mem [0:15];
    int  n_cmp = 0, n_bad = 0, done_cnt = 0;
    int  tries = 0, msg_reads = 0, bad_data = 0, bad_ptr = 0, full_left = 0, rx_hold = 0;
    bit  foreign_once = 0, full_seen = 0, wd = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rec_exp(input int i);
        case (i)
            0, 2:    return 32'd640;
            1, 3:    return 32'd480;
            5:       return 32'd24;
            default: return 32'd0;
        endcase
    endfunction

    // Record memory model: one-cycle acknowledge.
    initial begin
        int i;
        forever begin
            @(posedge clk);
            if (mem_req && !mem_ack) begin
                i = int'((mem_addr - BASE) >> 2);
                if (i < 0 || i > 9) check("R2 record address", mem_addr, BASE);
                else if (mem_we) mem[i] = mem_wdata;
                else mem_rdata <= mem[i];
                mem_ack <= 1'b1;
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // Mailbox plus coprocessor model.
    initial begin
        logic [27:0] rdat;
        logic [31:0] pv;
        forever begin
            @(posedge clk);
            if (mb_req && !mb_ack) begin
                mb_ack <= 1'b1;
                if (!mb_we && mb_addr == 8'h18) begin
                    full_seen = (full_left != 0);
                    mb_rdata <= {(full_left != 0), (rx_hold != 0) || (rxq.size() == 0), 30'b0};
                    if (full_left != 0) full_left--;
                    if (rx_hold != 0) rx_hold--;
                end else if (mb_we) begin
                    check("R4 post offset", {24'b0, mb_addr}, 32'h20);
                    check("R4 post value", mb_wdata, 32'h0040_0001);
                    check("R3 post while full", {31'b0, full_seen}, 32'd0);
                    for (int k = 0; k < 10; k++)
                        check(tries == 0 ? "R2 record word" : "R8 rebuilt word", mem[k], rec_exp(k));
                    tries++;
                    if (tries <= bad_data) begin
                        rdat = 28'h000_0003; pv = G_PTR;
                    end else if (tries <= bad_data + bad_ptr) begin
                        rdat = 28'h0; pv = 32'h0;
                    end else begin
                        rdat = 28'h0; pv = G_PTR;
                    end
                    mem[4] = G_PITCH;
                    mem[8] = pv;
                    mem[9] = G_SIZE;
                    if (foreign_once) begin
                        rxq.push_back({28'h123_4567, 4'h2});
                        foreign_once = 0;
                    end
                    rxq.push_back({rdat, 4'h1});
                    rx_hold = 2;
                end else if (mb_addr == 8'h00) begin
                    msg_reads++;
                    if (rx_hold != 0 || rxq.size() == 0) begin
                        check("R5 read while empty", 32'd1, 32'd0);
                        mb_rdata <= '0;
                    end else begin
                        mb_rdata <= rxq.pop_front();
                    end
                end
            end else begin
                mb_ack <= 1'b0;
            end
        end
    end

    // Monitor: pops the expected item on each done and compares.
    initial begin
        exp_t e;
        bit   prev;
        prev = 0;
        forever begin
            @(negedge clk);
            if (prev) check("R10 done one cycle", {31'b0, done}, 32'd0);
            if (done === 1'b1) begin
                if (sb.size() == 0) begin
                    check("R10 unexpected done", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    check(e.err ? "R9 ok" : "R7 ok", {31'b0, ok}, {31'b0, e.ok});
                    check("R9 err", {31'b0, err}, {31'b0, e.err});
                    check(e.err ? "R9 attempts" : "R8 attempts", tries, e.tries);
                    check("R6 message reads", msg_reads, e.reads);
                    if (e.vals) begin
                        check("R7 pitch", fb_pitch, e.pitch);
                        check("R7 pointer", fb_ptr, e.ptr);
                        check("R7 size", fb_size, e.size);
                    end
                end
                done_cnt++;
            end
            prev = done;
        end
    end

    task automatic run_case(input int bd, input int bp, input int fp, input bit fr, input exp_t e);
        int prev;
        bad_data = bd; bad_ptr = bp; full_left = fp; foreign_once = fr;
        tries = 0; msg_reads = 0; rxq.delete();
        sb.push_back(e);
        prev = done_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R10 ok cleared by start", {31'b0, ok}, 32'd0);
        check("R10 err cleared by start", {31'b0, err}, 32'd0);
        while (done_cnt == prev && !wd) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        wd = 1;
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done in reset", {31'b0, done}, 32'd0);
        check("R1 mb_req in reset", {31'b0, mb_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ok after reset", {31'b0, ok}, 32'd0);
        check("R1 err after reset", {31'b0, err}, 32'd0);
        check("R1 mem_req after reset", {31'b0, mem_req}, 32'd0);

        // Plain success on the first attempt.
        run_case(0, 0, 0, 0, '{1, 0, 1, 1, G_PITCH, G_PTR, G_SIZE, 1});
        repeat (5) @(negedge clk);
        check("R10 ok held", {31'b0, ok}, 32'd1);
        check("R10 pitch held", fb_pitch, G_PITCH);
        check("R10 size held", fb_size, G_SIZE);

        // Outbox full for three polls, one foreign-channel message first.
        run_case(0, 0, 3, 1, '{1, 0, 1, 2, G_PITCH, G_PTR, G_SIZE, 1});

        // Nonzero reply data, then null pointer, then success.
        run_case(1, 1, 0, 0, '{1, 0, 3, 3, G_PITCH, G_PTR, G_SIZE, 1});

        // Every attempt fails: limit reached.
        run_case(100, 0, 0, 0, '{0, 1, RMAX, RMAX, '0, '0, '0, 0});
        repeat (4) @(negedge clk);
        check("R9 no post after limit", tries, RMAX);

        // Recovery after an error run.
        run_case(0, 0, 1, 0, '{1, 0, 1, 1, G_PITCH, G_PTR, G_SIZE, 1});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule